// File: doc/BRIEF.md
# Two-Bank Interrupt Controller

This block gathers up to 64 raw interrupt inputs into a single request line for a processor. The sources are split into two banks of 32. Each bank offers four 32-bit registers on a small register bus: a latched event word, an enable word, a write-one-to-clear acknowledge word and a live level word. Every raw input passes through a two-flop synchronizer before anything else sees it.

Edge-type sources set their event bit on a rising edge, but only while enabled. Sources 20 to 28 of the low bank are level-type. They never latch, and they count as pending for exactly as long as their input is high and they are enabled. The request output is raised whenever any source is pending.

A status port shows every cycle whether anything is pending and which source has the highest number among the pending ones. Because bank 1 holds sources 32-63, searching bank 1 before bank 0 and taking the highest bit within a bank both come down to the same rule: the highest-numbered pending source wins.

Top module: `bnk_intc`

## Requirements
- R1: After a synchronous reset, every enable bit and every event bit is 0, and `irq_req` and `top_valid` are low.
- R2: Reading an enable word returns exactly the value last written to it. The enable word for sources 0-31 is at byte address 0x24 and the one for sources 32-63 is at 0x14. In every register, data bit n stands for source (bank base + n).
- R3: The level words read the current raw inputs after the two-flop synchronizer, so a change appears two clock edges later. They are at 0x2C for sources 0-31 and at 0x1C for sources 32-63.
- R4: An edge-type source sets its event bit one edge after its synchronized input rises, and only if its enable bit is 1 at that edge. The event words are at 0x20 for sources 0-31 and at 0x10 for sources 32-63.
- R5: Setting an enable bit while that source's input is already high sets no event bit and raises no request. Only a later rising edge does that.
- R6: Writing the acknowledge word clears every event bit written as 1 and leaves every bit written as 0 unchanged. The acknowledge words are at 0x28 and 0x18 and read as 0. If a rising edge and an acknowledge of the same bit fall in the same cycle, the event bit ends up set.
- R7: Sources 20-28 are level-type. Their event bits stay 0. They are pending only while their synchronized input is high and they are enabled, and they stop being pending as soon as the input drops.
- R8: A source is pending when (its event bit OR its level-type live input) AND its enable bit. `irq_req` is high exactly when at least one source is pending.
- R9: `top_valid` equals "any source pending", and `top_index` gives the number (0-63) of the highest-numbered pending source.
- R10: Byte addresses 0x00-0x0F and 0x30-0x3F read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 6 | Byte address within the 0x40 window (bits 1:0 ignored) |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_raw | input | 64 | Raw interrupt inputs, asynchronous |
| irq_req | output | 1 | Interrupt request to the processor |
| top_valid | output | 1 | At least one source pending |
| top_index | output | 6 | Number of the highest pending source |

## Verification
The hardest case to reach is a rising edge and an acknowledge of the same bit landing in the same clock cycle. The edge has to be timed so that it is detected exactly while the write strobe is sampled. The stimulus gets there by driving the input on a falling edge, counting two rising edges through the synchronizer, and only then issuing the acknowledge write, so that it meets the edge detection.

A second hard case is enabling a source whose input is already high. The stimulus reaches it by raising the input while the source is disabled, letting the synchronizer settle, and only then writing the enable. Random runs then mix input toggles, enable rewrites and acknowledges, and the full register set is compared with a bench model after every step.

// File: rtl/bnk_intc_pkg.sv
// Package: shared constants and address helpers for the two-bank interrupt controller.
// Assumes a 0x40-byte register window made of 32-bit words.
package bnk_intc_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned WIN_ADDR_W = 6;
    localparam int unsigned WORD_IDX_W = WIN_ADDR_W - 2;

    // Position of a register inside its four-word bank group
    typedef enum logic [1:0] {
        SLOT_EVENT  = 2'd0,
        SLOT_ENABLE = 2'd1,
        SLOT_ACK    = 2'd2,
        SLOT_LEVEL  = 2'd3
    } reg_slot_e;

    // Word index of a bank's first register: bank 0 at 0x20, bank 1 at 0x10
    function automatic logic [WORD_IDX_W-1:0] bank_word_base(input int unsigned b);
        return WORD_IDX_W'(8 - 4 * b);
    endfunction

    // Word index of a given slot within a given bank
    function automatic logic [WORD_IDX_W-1:0] slot_word(input int unsigned b, input reg_slot_e s);
        return bank_word_base(b) + WORD_IDX_W'(s);
    endfunction

endpackage

// File: rtl/bnk_intc_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous inputs.
// Assumes each bit is an independent level; no bus coherency is implied.
module bnk_intc_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages to settle metastable samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/bnk_intc_bank.sv
// Module: one 32-source bank with enable, latched events and write-one-to-clear acknowledge.
// Assumes sync_in has already been synchronized. Bits set in LVL_MASK are
// level-type: they never latch and are pending only while high. Event latching
// is gated by the enable value held before the clock edge, and a new edge wins
// over an acknowledge of the same bit.
module bnk_intc_bank #(
    parameter int unsigned   W        = 32,
    parameter logic [W-1:0]  LVL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_in,
    input  logic         en_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ev_q,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_mask;

    // Rising edges of enabled edge-type sources
    assign rise     = sync_in & ~prev_q & ~LVL_MASK & en_q;
    // Bits the current acknowledge write asks to clear
    assign clr_mask = ack_we ? wdata : '0;

    // Edge history, enable storage and event latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            en_q   <= '0;
            ev_q   <= '0;
        end else begin
            prev_q <= sync_in;
            if (en_we) begin
                en_q <= wdata;
            end
            ev_q <= (ev_q & ~clr_mask) | rise;
        end
    end

    // Pending: latched event or live level-type input, qualified by enable
    assign pend = (ev_q | (sync_in & LVL_MASK)) & en_q;

endmodule

// File: rtl/bnk_intc_pick.sv
// Module: selects the highest-numbered set bit of the pending vector.
// Assumes N is a power of two so that IDX_W bits cover every source.
module bnk_intc_pick #(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             valid,
    output logic [IDX_W-1:0] index
);

    // Ascending scan: the last set bit found, which is the highest, is kept
    always_comb begin
        valid = 1'b0;
        index = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (pend[i]) begin
                valid = 1'b1;
                index = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/bnk_intc.sv
// Module: two-bank interrupt controller top. It decodes the register window,
// synchronizes the raw inputs, instantiates one bank per 32 sources and
// reports the request and the highest pending source.
// Assumes single-cycle writes, combinational reads and word-aligned addresses.
module bnk_intc
    import bnk_intc_pkg::*;
#(
    parameter int unsigned                 NUM_BANKS = 2,
    parameter logic [NUM_BANKS*32-1:0]     LVL_MASK  = 64'h0000_0000_1ff0_0000
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [5:0]                         bus_addr,
    input  logic                               bus_wr,
    input  logic [31:0]                        bus_wdata,
    output logic [31:0]                        bus_rdata,
    input  logic [NUM_BANKS*32-1:0]            irq_raw,
    output logic                               irq_req,
    output logic                               top_valid,
    output logic [$clog2(NUM_BANKS*32)-1:0]    top_index
);

    localparam int unsigned NUM_SRC = NUM_BANKS * REG_W;
    localparam int unsigned IDX_W   = $clog2(NUM_SRC);

    logic [NUM_SRC-1:0]    sync_all;
    logic [NUM_SRC-1:0]    ev_all;
    logic [NUM_SRC-1:0]    en_all;
    logic [NUM_SRC-1:0]    pend_all;
    logic [REG_W-1:0]      bank_rd [NUM_BANKS];
    logic [WORD_IDX_W-1:0] word_idx;

    assign word_idx = bus_addr[WIN_ADDR_W-1:2];

    bnk_intc_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_raw),
        .sync_out (sync_all)
    );

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        localparam logic [WORD_IDX_W-1:0] W_EV  = slot_word(b, SLOT_EVENT);
        localparam logic [WORD_IDX_W-1:0] W_EN  = slot_word(b, SLOT_ENABLE);
        localparam logic [WORD_IDX_W-1:0] W_ACK = slot_word(b, SLOT_ACK);
        localparam logic [WORD_IDX_W-1:0] W_LVL = slot_word(b, SLOT_LEVEL);

        logic en_we;
        logic ack_we;

        // Write strobes for this bank's writable words
        assign en_we  = bus_wr && (word_idx == W_EN);
        assign ack_we = bus_wr && (word_idx == W_ACK);

        bnk_intc_bank #(
            .W        (REG_W),
            .LVL_MASK (LVL_MASK[b*REG_W +: REG_W])
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_all[b*REG_W +: REG_W]),
            .en_we   (en_we),
            .ack_we  (ack_we),
            .wdata   (bus_wdata),
            .ev_q    (ev_all[b*REG_W +: REG_W]),
            .en_q    (en_all[b*REG_W +: REG_W]),
            .pend    (pend_all[b*REG_W +: REG_W])
        );

        // Read selection for this bank; the acknowledge word reads as zero
        always_comb begin
            if (word_idx == W_EV) begin
                bank_rd[b] = ev_all[b*REG_W +: REG_W];
            end else if (word_idx == W_EN) begin
                bank_rd[b] = en_all[b*REG_W +: REG_W];
            end else if (word_idx == W_LVL) begin
                bank_rd[b] = sync_all[b*REG_W +: REG_W];
            end else begin
                bank_rd[b] = '0;
            end
        end
    end

    // Merge bank read data; bank address ranges do not overlap
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            bus_rdata = bus_rdata | bank_rd[b];
        end
    end

    // Request line: any pending source
    assign irq_req = |pend_all;

    bnk_intc_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .pend  (pend_all),
        .valid (top_valid),
        .index (top_index)
    );

endmodule

// File: rtl/bnk_intc_chk.sv
// Module: property checker for the interrupt controller, attached with bind.
// Assumes the default two-bank configuration.
module bnk_intc_chk #(
    parameter int unsigned NUM_SRC = 64,
    parameter int unsigned IDX_W   = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic [5:0]         bus_addr,
    input logic               bus_wr,
    input logic [31:0]        bus_wdata,
    input logic [31:0]        bus_rdata,
    input logic [NUM_SRC-1:0] irq_raw,
    input logic               irq_req,
    input logic               top_valid,
    input logic [IDX_W-1:0]   top_index,
    input logic [NUM_SRC-1:0] pend_all
);

    // R1: reset leaves no request and no valid index
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_req && !top_valid));

    // R2: enable word of bank 0 reads back what was written
    p_enable_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[5:2] == 4'h9) |=>
            (bus_addr[5:2] != 4'h9 || bus_rdata == $past(bus_wdata)));

    // R3: level word of bank 0 shows the input from two edges earlier
    p_level_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'hB && $past(rst_n, 1) && $past(rst_n, 2)) |->
            bus_rdata == $past(irq_raw[31:0], 2));

    // R7: level-type sources never show in the event word
    p_level_no_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[5:2] == 4'h8) |-> ((bus_rdata & 32'h1ff0_0000) == 32'h0));

    // R8: request and valid flag agree
    p_req_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == top_valid);

    // R9: the reported index is pending and nothing above it is
    p_index_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ((pend_all >> top_index) == NUM_SRC'(1)));

endmodule

bind bnk_intc bnk_intc_chk #(.NUM_SRC(64), .IDX_W(6)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_raw   (irq_raw),
    .irq_req   (irq_req),
    .top_valid (top_valid),
    .top_index (top_index),
    .pend_all  (pend_all)
);

// File: tb/bnk_intc_tb_top.sv
// Bench: directed corner cases plus seeded random steps, compared against a bench model.
module bnk_intc_tb_top;

    localparam logic [63:0] LVLM = 64'h0000_0000_1ff0_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [63:0] irq_raw;
    logic        irq_req;
    logic        top_valid;
    logic [5:0]  top_index;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [63:0] en_m;
    logic [63:0] ev_m;
    logic [63:0] raw_m;

    always #10 clk = ~clk;

    bnk_intc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_raw   (irq_raw),
        .irq_req   (irq_req),
        .top_valid (top_valid),
        .top_index (top_index)
    );

    function automatic logic [63:0] pend_of(input logic [63:0] ev, input logic [63:0] en,
                                            input logic [63:0] raw);
        return (ev | (raw & LVLM)) & en;
    endfunction

    function automatic int top_of(input logic [63:0] p);
        int r = -1;
        for (int i = 0; i < 64; i++) if (p[i]) r = i;
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_raw(input logic [63:0] v);
        ev_m  = ev_m | (v & ~raw_m & ~LVLM & en_m);
        raw_m = v;
        @(negedge clk);
        irq_raw = v;
        repeat (3) @(posedge clk);
    endtask

    task automatic set_en(input int bank, input logic [31:0] v);
        en_m[bank*32 +: 32] = v;
        wr(bank == 0 ? 6'h24 : 6'h14, v);
    endtask

    task automatic ack(input int bank, input logic [31:0] v);
        ev_m[bank*32 +: 32] = ev_m[bank*32 +: 32] & ~v;
        wr(bank == 0 ? 6'h28 : 6'h18, v);
    endtask

    // Compare every mapped register and the status outputs with the model
    task automatic check_all(input string req);
        logic [31:0] d;
        logic [63:0] p;
        int t;
        p = pend_of(ev_m, en_m, raw_m);
        t = top_of(p);
        rd(6'h20, d); chk({req, " R4 event0"}, 64'(d), 64'(ev_m[31:0]));
        rd(6'h10, d); chk({req, " R4 event1"}, 64'(d), 64'(ev_m[63:32]));
        rd(6'h24, d); chk({req, " R2 enable0"}, 64'(d), 64'(en_m[31:0]));
        rd(6'h14, d); chk({req, " R2 enable1"}, 64'(d), 64'(en_m[63:32]));
        rd(6'h2C, d); chk({req, " R3 level0"}, 64'(d), 64'(raw_m[31:0]));
        rd(6'h1C, d); chk({req, " R3 level1"}, 64'(d), 64'(raw_m[63:32]));
        rd(6'h28, d); chk({req, " R6 ack0 reads 0"}, 64'(d), 64'd0);
        chk({req, " R8 irq_req"}, 64'(irq_req), 64'(p != 64'd0));
        chk({req, " R9 top_valid"}, 64'(top_valid), 64'(t >= 0));
        if (t >= 0) chk({req, " R9 top_index"}, 64'(top_index), 64'(t));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; irq_raw = '0;
        en_m = '0; ev_m = '0; raw_m = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1 reset");

        // R2: enable readback in both banks
        set_en(0, 32'hA5A5_0001);
        set_en(1, 32'h0F0F_8000);
        check_all("R2 readback");
        set_en(0, 32'h0);
        set_en(1, 32'h0);

        // R5: input high before enable -> no event, no request
        set_raw(64'h20);
        set_en(0, 32'h20);
        check_all("R5 enable while high");
        rd(6'h20, d); chk("R5 no event bit 5", 64'(d), 64'd0);
        chk("R5 no request", 64'(irq_req), 64'd0);
        // R4: a new rising edge then latches
        set_raw(64'h0);
        set_raw(64'h20);
        check_all("R4 new edge");
        chk("R4 request after edge", 64'(irq_req), 64'd1);

        // R6: ack with zero bits keeps, ack with one clears
        ack(0, 32'hFFFF_FFDF);
        check_all("R6 ack zero bit kept");
        ack(0, 32'h20);
        check_all("R6 ack clears");

        // R6: edge and ack of the same bit in one cycle -> edge wins
        set_en(0, 32'h0000_0280);
        set_raw(64'h220);
        set_raw(64'h020);
        @(negedge clk);
        irq_raw = 64'h0A0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = 6'h28; bus_wdata = 32'h0000_0280; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        raw_m = 64'h0A0;
        ev_m  = (ev_m & ~64'h280) | 64'h80;
        check_all("R6 edge wins over ack");
        rd(6'h20, d); chk("R6 bit7 set bit9 cleared", 64'(d & 32'h280), 64'h80);
        ack(0, 32'hFFFF_FFFF);
        set_raw(64'h0);

        // R7: level-type source 22 is live, not latched
        set_en(0, 32'h0040_0000);
        set_raw(64'h0040_0000);
        check_all("R7 level pending");
        chk("R7 level index", 64'(top_index), 64'd22);
        set_raw(64'h0);
        check_all("R7 level drops");
        chk("R7 request gone", 64'(irq_req), 64'd0);

        // R9: highest pending wins across banks
        set_en(0, 32'h20);
        set_en(1, 32'h8000_0100);
        set_raw(64'h8000_0100_0000_0020);
        check_all("R9 three pending");
        chk("R9 top is 63", 64'(top_index), 64'd63);
        ack(1, 32'h8000_0000);
        check_all("R9 after ack of 63");
        chk("R9 top is 40", 64'(top_index), 64'd40);

        // R10: unmapped words read zero and writes do nothing
        wr(6'h04, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h0C, 32'hFFFF_FFFF);
        rd(6'h00, d); chk("R10 read 0x00", 64'(d), 64'd0);
        rd(6'h3C, d); chk("R10 read 0x3C", 64'(d), 64'd0);
        check_all("R10 writes ignored");

        // R8: random mix of input changes, enables and acknowledges
        for (int n = 0; n < 300; n++) begin
            int op = $urandom_range(0, 3);
            case (op)
                0: set_raw(raw_m ^ {$urandom() & $urandom(), $urandom() & $urandom()});
                1: set_en(n % 2, $urandom());
                2: ack(n % 2, $urandom());
                default: set_raw({$urandom() & $urandom() & $urandom(), $urandom()});
            endcase
            check_all("R8 random");
        end

        finish_run();
    end

endmodule